// File: doc/BRIEF.md
# In-System Flash Configuration Target Behind a Test Access Port

This block is the device-side logic that sits behind a test access port and lets an external debugger configure an on-chip flash. The port's state machine is outside the block. It delivers one-cycle capture, shift and update strobes for the instruction path and for the data path, together with the serial input bit. The block keeps an 8-bit instruction register, uses the current opcode to pick a data register of the right length, and returns the low bit of the active shift register on the serial output.

Behind the data registers is a small behavioural flash model. It holds a register file of 64-bit sectors, a 64-bit option word and a security flag. An in-system mode flag must be set before any programming, erase or blank-check operation is accepted. Each accepted operation starts a timer of parameterised length, and the timer drives a busy output. A debugger reads the status byte by capturing under the no-op instruction.

Top module: `isc_flash_target`

## Requirements
- R1: The reset state (rst_n low at a clock edge) is: current instruction 0xFE (identity), mode flag 0, result code 0, not busy, option word 0, security 0, every sector all-ones (erased), address 0.
- R2: The instruction register is 8 bits wide. An instruction capture loads 0x01. Each shift moves the serial input in at bit 7 and shifts right. An update makes the shifted value the current instruction. The serial output is bit 0 of the instruction shift register while instruction shift is high, and bit 0 of the data shift register otherwise. Data registers shift in the same way, entering at their top bit.
- R3: Under opcode 0xFE the data register is 32 bits long and a capture loads the ID_CODE parameter.
- R4: Under opcode 0x10 the data register is 8 bits long and a capture loads the status byte. Its fields are: bit 6 security, bits 5:4 internal error (always 0), bit 3 mode, bit 2 done (1 when idle, 0 while busy), bits 1:0 result code. Result codes are 1 invalid command, 2 success, 3 mode off.
- R5: An update of opcode 0x0C sets the mode flag and an update of 0x0F clears it. Both are shown on isc_mode. An update of 0x13 sets the result code to 0.
- R6: Under opcode 0x11 the data register is 8 bits long. An update stores its value as the address, and a capture returns the stored address.
- R7: A data update under opcode 0x20 (64 bits) does one of three things. At address 0x50 it ORs the data into the option word. At an address below NUM_SECT it ANDs the data into that sector. In both cases the result is 2 and the timer starts. At any other address the result is 1, nothing changes and the timer does not start.
- R8: A data update under opcode 0x30 (64-bit mask) acts as follows. An all-ones mask erases every sector, clears the option word and clears security. Otherwise, if mask bit 49 is set, only the option word is cleared. Otherwise every sector i whose mask bit i is set becomes all-ones. Each erase sets result 2 and starts the timer.
- R9: A data update under opcode 0x60 (64-bit mask) records one bit per sector: 1 when the sector is selected and not all-ones. The next capture under 0x60 returns that record. The update sets result 2 and starts the timer.
- R10: An instruction update of 0x22 with address 0x80 sets security, sets result 2 and starts the timer. With any other address it sets result 1.
- R11: When the mode flag is 0, the operations of R7 to R10 change nothing, set result 3 and do not start the timer.
- R12: An accepted operation holds op_busy high (done low) for OP_CYCLES cycles. A program, erase, blank-check or security request that arrives while busy is ignored entirely.
- R13: An instruction update with an opcode outside the known set sets result 1. Such an opcode, like any opcode that has no data register of its own, selects a 1-bit register that captures 0.
- R14: Under opcode 0x50 (64 bits) a capture returns the sector at the stored address, or the option word when the address is 0x50, or 0 for any other address. Under opcode 0x07 (64 bits) a capture returns the option word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdi | input | 1 | Serial data in |
| ir_capture | input | 1 | Instruction capture strobe |
| ir_shift | input | 1 | Instruction shift strobe |
| ir_update | input | 1 | Instruction update strobe |
| dr_capture | input | 1 | Data capture strobe |
| dr_shift | input | 1 | Data shift strobe |
| dr_update | input | 1 | Data update strobe |
| tdo | output | 1 | Serial data out |
| isc_mode | output | 1 | In-system configuration mode flag |
| op_busy | output | 1 | Flash operation timer running |

## Verification
The assertions assume that the six port strobes are mutually exclusive in every cycle, as the state machine of a real port guarantees, and one assertion checks that assumption. They also assume that an update always follows a capture and a complete shift of the selected length. The bench drives every scan through tasks that raise exactly one strobe per cycle and shift exactly the length the current opcode selects. Several operations are started inside the busy window on purpose, to exercise the ignore rule.

// File: rtl/isc_flash_pkg.sv
// Shared opcodes, result codes and data-register lengths for the flash target.
// Assumes an 8-bit instruction register and data registers of at most 64 bits.
package isc_flash_pkg;
    localparam int IR_W = 8;
    localparam int DR_MAX = 64;

    localparam logic [IR_W-1:0] OP_IDENT    = 8'hFE;
    localparam logic [IR_W-1:0] OP_MFG      = 8'h4C;
    localparam logic [IR_W-1:0] OP_OPTIONS  = 8'h07;
    localparam logic [IR_W-1:0] OP_MODE_ON  = 8'h0C;
    localparam logic [IR_W-1:0] OP_MODE_OFF = 8'h0F;
    localparam logic [IR_W-1:0] OP_POLL     = 8'h10;
    localparam logic [IR_W-1:0] OP_ADDR     = 8'h11;
    localparam logic [IR_W-1:0] OP_CLEAR    = 8'h13;
    localparam logic [IR_W-1:0] OP_WRITE    = 8'h20;
    localparam logic [IR_W-1:0] OP_SECURE   = 8'h22;
    localparam logic [IR_W-1:0] OP_ERASE    = 8'h30;
    localparam logic [IR_W-1:0] OP_FETCH    = 8'h50;
    localparam logic [IR_W-1:0] OP_BLANK    = 8'h60;

    localparam logic [7:0] ADDR_OPTIONS  = 8'h50;
    localparam logic [7:0] ADDR_SECURITY = 8'h80;
    localparam int OPT_ERASE_BIT = 49;

    localparam logic [1:0] RES_NONE     = 2'd0;
    localparam logic [1:0] RES_INVALID  = 2'd1;
    localparam logic [1:0] RES_OK       = 2'd2;
    localparam logic [1:0] RES_MODE_OFF = 2'd3;

    // Data-register length selected by an opcode.
    function automatic int unsigned dr_length(input logic [IR_W-1:0] op);
        case (op)
            OP_IDENT:                                          return 32;
            OP_POLL, OP_ADDR:                                  return 8;
            OP_OPTIONS, OP_WRITE, OP_ERASE, OP_FETCH, OP_BLANK: return 64;
            default:                                           return 1;
        endcase
    endfunction

    // True for every opcode the target recognises.
    function automatic logic op_known(input logic [IR_W-1:0] op);
        case (op)
            OP_IDENT, OP_MFG, OP_OPTIONS, OP_MODE_ON, OP_MODE_OFF, OP_POLL,
            OP_ADDR, OP_CLEAR, OP_WRITE, OP_SECURE, OP_ERASE, OP_FETCH,
            OP_BLANK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/isc_ir_unit.sv
// Instruction register: capture of the fixed pattern, LSB-first shift and the
// current-instruction latch. Assumes the strobes are mutually exclusive.
module isc_ir_unit
    import isc_flash_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tdi,
    input  logic            ir_capture,
    input  logic            ir_shift,
    input  logic            ir_update,
    output logic [IR_W-1:0] ir_sr,
    output logic [IR_W-1:0] instr
);
    localparam logic [IR_W-1:0] CAPTURE_PAT = IR_W'(1);

    // Shift register and current-instruction latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_sr <= '0;
            instr <= OP_IDENT;
        end else begin
            if (ir_capture)
                ir_sr <= CAPTURE_PAT;
            else if (ir_shift)
                ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            if (ir_update)
                instr <= ir_sr;
        end
    end

    // R2: a capture always leaves the fixed pattern in the shift register.
    a_r2_capture_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        ir_capture |=> (ir_sr == CAPTURE_PAT));
endmodule

// File: rtl/isc_dr_chain.sv
// Data shift register whose length follows the current instruction. Captures a
// zero-extended value from the core and enters serial data at the top bit.
module isc_dr_chain
    import isc_flash_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tdi,
    input  logic              dr_capture,
    input  logic              dr_shift,
    input  logic [IR_W-1:0]   instr,
    input  logic [DR_MAX-1:0] cap_val,
    output logic [DR_MAX-1:0] dr_sr
);
    localparam int LW = $clog2(DR_MAX);

    logic [LW-1:0]     top_idx;
    logic [DR_MAX-1:0] shifted;

    // Next value for one shift step at the selected length.
    always_comb begin
        top_idx = LW'(dr_length(instr) - 1);
        shifted = dr_sr >> 1;
        shifted[top_idx] = tdi;
    end

    // Capture or shift the data register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dr_sr <= '0;
        else if (dr_capture)
            dr_sr <= cap_val;
        else if (dr_shift)
            dr_sr <= shifted;
    end

    // R2: shifting a one-bit register leaves the serial input in bit 0.
    a_r2_short_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_shift && dr_length(instr) == 1) |=> (dr_sr[0] == $past(tdi)));
endmodule

// File: rtl/isc_op_timer.sv
// Behavioural flash-operation timer: busy for OP_CYCLES cycles after a start.
// Assumes start is only raised while idle.
module isc_op_timer #(
    parameter int OP_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(OP_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(OP_CYCLES);

    logic [CW-1:0] remain;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= LOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R12: a start is followed by a busy cycle.
    a_r12_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R12: busy only ends when the count has run down to one.
    a_r12_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(remain) == CW'(1)));
endmodule

// File: rtl/isc_flash_core.sv
// Flash model and command logic: mode flag, address, option word, security,
// sector register file, blank-check record, result code and capture mux.
// Assumes update strobes arrive only after a complete shift.
module isc_flash_core
    import isc_flash_pkg::*;
#(
    parameter logic [31:0] ID_CODE  = 32'h1A5F_0041,
    parameter int          NUM_SECT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_update,
    input  logic              dr_update,
    input  logic [IR_W-1:0]   ir_sr,
    input  logic [IR_W-1:0]   instr,
    input  logic [DR_MAX-1:0] dr_val,
    input  logic              busy,
    output logic              launch,
    output logic              mode,
    output logic [DR_MAX-1:0] cap_val
);
    localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
    localparam logic [7:0] SECT_LIM = 8'(NUM_SECT);

    logic [DR_MAX-1:0] mem [NUM_SECT];
    logic [DR_MAX-1:0] opt_word;
    logic [DR_MAX-1:0] blank_rec;
    logic [DR_MAX-1:0] dirty;
    logic [7:0]        addr;
    logic [1:0]        result;
    logic              secure;
    logic              in_array;
    logic [SW-1:0]     sidx;
    logic [7:0]        status;
    logic              flash_op;

    assign in_array = (addr < SECT_LIM);
    assign sidx     = addr[SW-1:0];
    assign status   = {1'b0, secure, 2'b00, mode, ~busy, result};
    assign flash_op = (instr == OP_WRITE) || (instr == OP_ERASE) || (instr == OP_BLANK);

    // One bit per sector: set when the sector holds any programmed bit.
    for (genvar g = 0; g < DR_MAX; g++) begin : g_dirty
        if (g < NUM_SECT) begin : g_sect
            assign dirty[g] = (mem[g] != '1);
        end else begin : g_none
            assign dirty[g] = 1'b0;
        end
    end

    // Decide whether this cycle starts a timed flash operation.
    always_comb begin
        launch = 1'b0;
        if (!busy && mode) begin
            if (ir_update && ir_sr == OP_SECURE && addr == ADDR_SECURITY)
                launch = 1'b1;
            if (dr_update && flash_op &&
                (instr != OP_WRITE || addr == ADDR_OPTIONS || in_array))
                launch = 1'b1;
        end
    end

    // Value loaded into the data register on capture.
    always_comb begin
        case (instr)
            OP_IDENT:   cap_val = {32'h0, ID_CODE};
            OP_OPTIONS: cap_val = opt_word;
            OP_POLL:    cap_val = {56'h0, status};
            OP_ADDR:    cap_val = {56'h0, addr};
            OP_BLANK:   cap_val = blank_rec;
            OP_FETCH:   cap_val = in_array ? mem[sidx] :
                                  (addr == ADDR_OPTIONS) ? opt_word : '0;
            default:    cap_val = '0;
        endcase
    end

    // Apply instruction and data updates to the flash model state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= 1'b0;
            secure    <= 1'b0;
            result    <= RES_NONE;
            addr      <= '0;
            opt_word  <= '0;
            blank_rec <= '0;
            for (int i = 0; i < NUM_SECT; i++) mem[i] <= '1;
        end else begin
            if (ir_update) begin
                case (ir_sr)
                    OP_MODE_ON:  mode <= 1'b1;
                    OP_MODE_OFF: mode <= 1'b0;
                    OP_CLEAR:    result <= RES_NONE;
                    OP_SECURE: begin
                        if (!busy) begin
                            if (!mode)
                                result <= RES_MODE_OFF;
                            else if (addr == ADDR_SECURITY) begin
                                secure <= 1'b1;
                                result <= RES_OK;
                            end else
                                result <= RES_INVALID;
                        end
                    end
                    default: if (!op_known(ir_sr)) result <= RES_INVALID;
                endcase
            end
            if (dr_update) begin
                if (instr == OP_ADDR)
                    addr <= dr_val[7:0];
                else if (flash_op && !busy) begin
                    if (!mode)
                        result <= RES_MODE_OFF;
                    else begin
                        case (instr)
                            OP_WRITE: begin
                                if (addr == ADDR_OPTIONS) begin
                                    opt_word <= opt_word | dr_val;
                                    result   <= RES_OK;
                                end else if (in_array) begin
                                    mem[sidx] <= mem[sidx] & dr_val;
                                    result    <= RES_OK;
                                end else
                                    result <= RES_INVALID;
                            end
                            OP_ERASE: begin
                                result <= RES_OK;
                                if (&dr_val) begin
                                    for (int i = 0; i < NUM_SECT; i++) mem[i] <= '1;
                                    opt_word <= '0;
                                    secure   <= 1'b0;
                                end else if (dr_val[OPT_ERASE_BIT])
                                    opt_word <= '0;
                                else begin
                                    for (int i = 0; i < NUM_SECT; i++)
                                        if (dr_val[i]) mem[i] <= '1;
                                end
                            end
                            default: begin
                                blank_rec <= dr_val & dirty;
                                result    <= RES_OK;
                            end
                        endcase
                    end
                end
            end
        end
    end

    // R5: the enable opcode leaves the mode flag set.
    a_r5_mode_on: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_update && ir_sr == OP_MODE_ON) |=> mode);
    // R11: an erase request with the mode flag off reports the mode-off code.
    a_r11_mode_off_code: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_update && instr == OP_ERASE && !mode && !busy) |=> (result == RES_MODE_OFF));
    // R8: security only drops through an erase update.
    a_r8_security_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(secure) |-> $past(dr_update && instr == OP_ERASE));
    // R12: no operation starts while the timer is running.
    a_r12_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy);
endmodule

// File: rtl/isc_flash_target.sv
// Top: instruction register, data chain, flash core and operation timer behind
// a test access port whose state machine supplies one-cycle strobes.
module isc_flash_target
    import isc_flash_pkg::*;
#(
    parameter logic [31:0] ID_CODE   = 32'h1A5F_0041,
    parameter int          NUM_SECT  = 8,
    parameter int          OP_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tdi,
    input  logic ir_capture,
    input  logic ir_shift,
    input  logic ir_update,
    input  logic dr_capture,
    input  logic dr_shift,
    input  logic dr_update,
    output logic tdo,
    output logic isc_mode,
    output logic op_busy
);
    logic [IR_W-1:0]   ir_sr;
    logic [IR_W-1:0]   instr;
    logic [DR_MAX-1:0] dr_sr;
    logic [DR_MAX-1:0] cap_val;
    logic              launch;

    isc_ir_unit u_ir (
        .clk(clk), .rst_n(rst_n), .tdi(tdi),
        .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
        .ir_sr(ir_sr), .instr(instr)
    );

    isc_dr_chain u_dr (
        .clk(clk), .rst_n(rst_n), .tdi(tdi),
        .dr_capture(dr_capture), .dr_shift(dr_shift),
        .instr(instr), .cap_val(cap_val), .dr_sr(dr_sr)
    );

    isc_flash_core #(.ID_CODE(ID_CODE), .NUM_SECT(NUM_SECT)) u_core (
        .clk(clk), .rst_n(rst_n), .ir_update(ir_update), .dr_update(dr_update),
        .ir_sr(ir_sr), .instr(instr), .dr_val(dr_sr), .busy(op_busy),
        .launch(launch), .mode(isc_mode), .cap_val(cap_val)
    );

    isc_op_timer #(.OP_CYCLES(OP_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(launch), .busy(op_busy)
    );

    // Serial output follows whichever shift register is active.
    assign tdo = ir_shift ? ir_sr[0] : dr_sr[0];

    // R2: the port strobes are never raised together.
    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ir_capture, ir_shift, ir_update, dr_capture, dr_shift, dr_update}));
endmodule

// File: tb/sim_isc_flash_target.sv
module sim_isc_flash_target;
    localparam logic [31:0] ID = 32'h1A5F_0041;
    localparam int NS = 8;
    localparam int OPC = 100;
    localparam logic [63:0] D1 = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] OPTV = 64'h000F_0000_0000_00A0;
    localparam logic [63:0] ONES = '1;

    logic clk = 1'b0, rst_n = 1'b0, tdi = 1'b0;
    logic ir_capture = 0, ir_shift = 0, ir_update = 0;
    logic dr_capture = 0, dr_shift = 0, dr_update = 0;
    logic tdo, isc_mode, op_busy;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    isc_flash_target #(.ID_CODE(ID), .NUM_SECT(NS), .OP_CYCLES(OPC)) u0 (
        .clk(clk), .rst_n(rst_n), .tdi(tdi),
        .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .tdo(tdo), .isc_mode(isc_mode), .op_busy(op_busy)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_ir, m_instr, m_addr;
    logic [63:0] m_dr, m_opt, m_blank;
    logic [63:0] m_mem [NS];
    logic [1:0]  m_res;
    logic        m_mode, m_sec;
    int          m_cnt;

    function automatic int mlen(input logic [7:0] op);
        if (op == 8'hFE) return 32;
        if (op == 8'h10 || op == 8'h11) return 8;
        if (op == 8'h07 || op == 8'h20 || op == 8'h30 || op == 8'h50 || op == 8'h60) return 64;
        return 1;
    endfunction

    function automatic bit mknown(input logic [7:0] op);
        logic [7:0] ops [13] = '{8'hFE, 8'h4C, 8'h07, 8'h0C, 8'h0F, 8'h10, 8'h11,
                                 8'h13, 8'h20, 8'h22, 8'h30, 8'h50, 8'h60};
        foreach (ops[k]) if (ops[k] == op) return 1;
        return 0;
    endfunction

    function automatic logic [63:0] mcap();
        bit b = (m_cnt != 0);
        case (m_instr)
            8'hFE: return {32'h0, ID};
            8'h07: return m_opt;
            8'h10: return {56'h0, 1'b0, m_sec, 2'b00, m_mode, !b, m_res};
            8'h11: return {56'h0, m_addr};
            8'h60: return m_blank;
            8'h50: return (m_addr < NS) ? m_mem[m_addr] : (m_addr == 8'h50) ? m_opt : 64'h0;
            default: return 64'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit was_busy, go;
        int n;
        if (!rst_n) begin
            m_ir = 0; m_instr = 8'hFE; m_addr = 0; m_dr = 0; m_opt = 0; m_blank = 0;
            m_res = 0; m_mode = 0; m_sec = 0; m_cnt = 0;
            for (int i = 0; i < NS; i++) m_mem[i] = ONES;
        end else begin
            was_busy = (m_cnt != 0);
            go = 0;
            if (ir_capture) m_ir = 8'h01;
            if (ir_shift) m_ir = {tdi, m_ir[7:1]};
            if (dr_capture) m_dr = mcap();
            if (dr_shift) begin
                n = mlen(m_instr);
                m_dr = m_dr >> 1;
                m_dr[n-1] = tdi;
            end
            if (ir_update) begin
                m_instr = m_ir;
                if (m_ir == 8'h0C) m_mode = 1;
                else if (m_ir == 8'h0F) m_mode = 0;
                else if (m_ir == 8'h13) m_res = 0;
                else if (m_ir == 8'h22) begin
                    if (!was_busy) begin
                        if (!m_mode) m_res = 3;
                        else if (m_addr == 8'h80) begin m_sec = 1; m_res = 2; go = 1; end
                        else m_res = 1;
                    end
                end else if (!mknown(m_ir)) m_res = 1;
            end
            if (dr_update) begin
                if (m_instr == 8'h11) m_addr = m_dr[7:0];
                else if ((m_instr == 8'h20 || m_instr == 8'h30 || m_instr == 8'h60) && !was_busy) begin
                    if (!m_mode) m_res = 3;
                    else if (m_instr == 8'h20) begin
                        if (m_addr == 8'h50) begin m_opt |= m_dr; m_res = 2; go = 1; end
                        else if (m_addr < NS) begin m_mem[m_addr] &= m_dr; m_res = 2; go = 1; end
                        else m_res = 1;
                    end else if (m_instr == 8'h30) begin
                        m_res = 2; go = 1;
                        if (m_dr == ONES) begin
                            for (int i = 0; i < NS; i++) m_mem[i] = ONES;
                            m_opt = 0; m_sec = 0;
                        end else if (m_dr[49]) m_opt = 0;
                        else for (int i = 0; i < NS; i++) if (m_dr[i]) m_mem[i] = ONES;
                    end else begin
                        m_blank = 0;
                        for (int i = 0; i < NS; i++) m_blank[i] = m_dr[i] && (m_mem[i] != ONES);
                        m_res = 2; go = 1;
                    end
                end
            end
            if (go) m_cnt = OPC;
            else if (m_cnt != 0) m_cnt = m_cnt - 1;
        end
    end

    // Per-cycle comparison, sampled between edges.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            checks += 3;
            if (tdo !== (ir_shift ? m_ir[0] : m_dr[0])) begin
                errors++;
                $display("FAIL R2 tdo act=%b exp=%b t=%0t", tdo, ir_shift ? m_ir[0] : m_dr[0], $time);
            end
            if (isc_mode !== m_mode) begin
                errors++;
                $display("FAIL R5 isc_mode act=%b exp=%b t=%0t", isc_mode, m_mode, $time);
            end
            if (op_busy !== (m_cnt != 0)) begin
                errors++;
                $display("FAIL R12 op_busy act=%b exp=%b t=%0t", op_busy, m_cnt != 0, $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic load_ir(input logic [7:0] op, output logic [7:0] cap);
        @(negedge clk); ir_capture = 1;
        @(negedge clk); ir_capture = 0; ir_shift = 1;
        for (int i = 0; i < 8; i++) begin
            tdi = op[i]; #1; cap[i] = tdo;
            @(negedge clk);
        end
        ir_shift = 0; ir_update = 1;
        @(negedge clk); ir_update = 0;
    endtask

    task automatic ir(input logic [7:0] op);
        logic [7:0] c;
        load_ir(op, c);
    endtask

    task automatic scan(input int len, input logic [63:0] din, output logic [63:0] dout);
        dout = 0;
        @(negedge clk); dr_capture = 1;
        @(negedge clk); dr_capture = 0; dr_shift = 1;
        for (int i = 0; i < len; i++) begin
            tdi = din[i]; #1; dout[i] = tdo;
            @(negedge clk);
        end
        dr_shift = 0; dr_update = 1;
        @(negedge clk); dr_update = 0;
    endtask

    task automatic status(input string req, input logic [7:0] exp);
        logic [63:0] d;
        ir(8'h10);
        scan(8, 0, d);
        chk(req, d, {56'h0, exp});
    endtask

    task automatic set_addr(input logic [7:0] a);
        logic [63:0] d;
        ir(8'h11);
        scan(8, {56'h0, a}, d);
    endtask

    task automatic wait_idle();
        repeat (OPC + 10) @(negedge clk);
    endtask

    // ---------------- test sequence ----------------
    initial begin
        logic [7:0] c;
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #2;
        chk("R1 mode after reset", {63'h0, isc_mode}, 0);
        chk("R1 busy after reset", {63'h0, op_busy}, 0);
        scan(32, 0, d);
        chk("R1 R3 identity after reset", d, {32'h0, ID});
        load_ir(8'h10, c);
        chk("R2 instruction capture pattern", {56'h0, c}, 64'h01);
        scan(8, 0, d);
        chk("R1 R4 reset status", d, 64'h04);
        ir(8'h30); scan(64, ONES, d);
        chk("R11 erase out of mode not busy", {63'h0, op_busy}, 0);
        status("R11 mode-off result", 8'h07);
        ir(8'h13);
        status("R5 clear result", 8'h04);
        ir(8'h0C);
        #2 chk("R5 mode set", {63'h0, isc_mode}, 1);
        status("R4 R5 status in mode", 8'h0C);
        set_addr(8'h03);
        ir(8'h11); scan(8, 64'h03, d);
        chk("R6 address capture", d, 64'h03);
        ir(8'h20); scan(64, D1, d);
        #2 chk("R12 busy after program", {63'h0, op_busy}, 1);
        scan(64, 64'h0, d);
        status("R12 done low while busy", 8'h0A);
        wait_idle();
        status("R7 program success", 8'h0E);
        ir(8'h50); scan(64, 0, d);
        chk("R7 R12 sector contents, busy program ignored", d, D1);
        ir(8'h60); scan(64, 64'h28, d);
        scan(64, 0, d);
        chk("R9 blank record", d, 64'h08);
        wait_idle();
        set_addr(8'h50);
        ir(8'h20); scan(64, OPTV, d);
        wait_idle();
        ir(8'h07); scan(64, 0, d);
        chk("R7 R14 option word", d, OPTV);
        ir(8'h50); scan(64, 0, d);
        chk("R14 fetch option address", d, OPTV);
        ir(8'h30); scan(64, 64'h1 << 49, d);
        wait_idle();
        ir(8'h07); scan(64, 0, d);
        chk("R8 option erase", d, 0);
        set_addr(8'h03);
        ir(8'h50); scan(64, 0, d);
        chk("R8 option erase keeps sector", d, D1);
        set_addr(8'h80);
        ir(8'h22);
        wait_idle();
        status("R10 security set", 8'h4E);
        set_addr(8'h21);
        ir(8'h20); scan(64, 0, d);
        #2 chk("R7 bad address not busy", {63'h0, op_busy}, 0);
        status("R7 bad address result", 8'h4D);
        ir(8'h13);
        status("R5 clear keeps security", 8'h4C);
        ir(8'h55); scan(1, 1, d);
        chk("R13 one-bit register captures 0", d, 0);
        status("R13 unknown opcode result", 8'h4D);
        ir(8'h30); scan(64, ONES, d);
        wait_idle();
        status("R8 full erase clears security", 8'h0E);
        set_addr(8'h03);
        ir(8'h50); scan(64, 0, d);
        chk("R8 full erase sector", d, ONES);
        ir(8'h0F);
        #2 chk("R5 mode cleared", {63'h0, isc_mode}, 0);
        status("R5 status out of mode", 8'h06);
        ir(8'h20); scan(64, 0, d);
        #2 chk("R11 program out of mode not busy", {63'h0, op_busy}, 0);
        status("R11 program mode-off result", 8'h07);
        ir(8'h50); scan(64, 0, d);
        chk("R11 sector unchanged", d, ONES);
        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule